// File: doc/BRIEF.md
# Luminance step transient sharpener

This block sharpens a stream of unsigned luminance samples that arrive at most one per clock, each marked by a valid strobe. Every accepted sample enters a five-stage tapped window. Over that window the block finds the smallest and the largest value, and their difference is the local envelope. A second-derivative contour taken across the full window decides whether the step output is the window maximum or the window minimum. Each output is therefore pulled to one side of an edge, which makes the edge steeper.

A second path produces a peaked detail signal. It adds a contour correction to the window centre. The correction comes from a three-tap or a five-tap contour kernel, chosen by a configuration bit. Small contour values are zeroed by a coring threshold. The rest is scaled by a six-bit gain, and that gain is weakened as the envelope grows, so large swings are peaked less than fine detail. The peaked result saturates to the sample range.

All three results leave the block together through output registers. A delayed copy of the strobe marks them valid. Configuration inputs are plain register values and are sampled when the outputs are captured.

Top module: `luma_step_sharpener`

## Requirements
- R1: The window shifts only on a cycle with `in_valid` high. Cycles with `in_valid` low leave the window untouched, whatever is on `in_luma`. With the five most recent accepted samples a (oldest), b, c, d, e (newest), the centre sample is c.
- R2: `out_env` equals the largest minus the smallest of a..e.
- R3: The wide contour is 2c - a - e. `out_step` is the window maximum when the wide contour is negative. It is the window minimum when the wide contour is zero or positive.
- R4: The peaking contour is the narrow kernel 2c - b - d when `cfg_wide` is 0, and the wide kernel 2c - a - e when `cfg_wide` is 1.
- R5: A peaking contour whose magnitude is at most `cfg_core` is treated as zero. `out_peak` then equals c.
- R6: The gain weight w is `cfg_gain`, except that code 63 maps to 64. The effective gain is floor(w*(256-env)/256), and the correction is floor(cored contour * effective gain / 64). Gain code 0 gives `out_peak` equal to c.
- R7: `out_peak` is c plus the correction, clamped to 0..255.
- R8: `out_valid` is `in_valid` delayed by exactly two clocks. The outputs update only in the cycle where `out_valid` rises for that sample, and they hold their values otherwise.
- R9: During and right after reset, all outputs are 0, `out_valid` is 0 and the window holds zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Marks `in_luma` as a sample to accept |
| in_luma | input | 8 | Incoming luminance sample |
| cfg_wide | input | 1 | Peaking kernel select: 0 narrow, 1 wide |
| cfg_gain | input | 6 | Peaking gain code, 63 means full scale |
| cfg_core | input | 6 | Coring threshold on contour magnitude |
| out_valid | output | 1 | Marks the three results as new |
| out_step | output | 8 | Step-improved luminance (window min or max) |
| out_peak | output | 8 | Peaked and saturated luminance |
| out_env | output | 8 | Window envelope, max minus min |

## Verification
The step decision and the peaking path read the same window in the same cycle, so a single sample can hit the zero tie of the step decision and the coring threshold at once. The stimulus table builds flat-edged windows whose wide contour is exactly zero. It also contains a pair of identical windows that differ only in having the coring threshold equal to the contour magnitude or one below it. The bench judges each of these by comparing the step result and the peaked result against values worked out by hand from the requirements. A further case sets the envelope and the gain weakening strongly in the same window as a saturating correction. This shows that the clamp and the envelope scaling combine in the stated order.

// File: rtl/lss_pkg.sv
package lss_pkg;

  localparam int NTAP    = 5;
  localparam int CTR_IDX = 2;

  typedef enum logic {
    KSEL_NARROW = 1'b0,
    KSEL_WIDE   = 1'b1
  } ksel_e;

  function automatic int clamp_i(int v, int lo, int hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction

  function automatic int core_i(int c, int thr);
    if ((c <= thr) && (c >= -thr)) return 0;
    return c;
  endfunction

  function automatic int eff_gain_i(int g, int gw, int env, int dw);
    int w;
    w = (g == ((1 << gw) - 1)) ? (1 << gw) : g;
    return (w * ((1 << dw) - env)) >>> dw;
  endfunction

  function automatic int corr_i(int cored, int eff, int gw);
    return (cored * eff) >>> gw;
  endfunction

endpackage

// File: rtl/lss_taps.sv
module lss_taps
  import lss_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      shift,
  input  logic [DW-1:0]             din,
  output logic [NTAP-1:0][DW-1:0]   taps
);

  logic [NTAP-1:0][DW-1:0] taps_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      taps_q[0] <= '0;
    else if (shift)  taps_q[0] <= din;
  end

  for (genvar i = 1; i < NTAP; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n)      taps_q[i] <= '0;
      else if (shift)  taps_q[i] <= taps_q[i-1];
    end
  end

  assign taps = taps_q;

  // R1: a shift moves the newest sample one stage down
  a_r1_shift_moves: assert property (@(posedge clk) disable iff (!rst_n)
    shift |=> (taps_q[1] == $past(taps_q[0])));
  // R1: no shift, no change
  a_r1_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !shift |=> $stable(taps_q));

endmodule

// File: rtl/lss_envelope.sv
module lss_envelope
  import lss_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NTAP-1:0][DW-1:0]   taps,
  output logic [DW-1:0]             win_min,
  output logic [DW-1:0]             win_max,
  output logic [DW-1:0]             win_env
);

  always_comb begin
    win_min = taps[0];
    win_max = taps[0];
    for (int i = 1; i < NTAP; i++) begin
      if (taps[i] < win_min) win_min = taps[i];
      if (taps[i] > win_max) win_max = taps[i];
    end
  end

  assign win_env = win_max - win_min;

  // R2: every tap, the centre included, lies inside the envelope
  a_r2_centre_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    (win_min <= taps[CTR_IDX]) && (taps[CTR_IDX] <= win_max));
  a_r2_edges_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    (win_min <= taps[0]) && (win_min <= taps[NTAP-1]) &&
    (taps[0] <= win_max) && (taps[NTAP-1] <= win_max));

endmodule

// File: rtl/lss_contour.sv
module lss_contour
  import lss_pkg::*;
#(
  parameter int DW   = 8,
  parameter bit WIDE = 1'b1,
  localparam int CW  = DW + 3
) (
  input  logic [NTAP-1:0][DW-1:0] taps,
  output logic signed [CW-1:0]    ctr
);

  localparam int OFF = WIDE ? 2 : 1;

  int side_l, side_r, mid;

  assign mid    = int'(taps[CTR_IDX]);
  assign side_l = int'(taps[CTR_IDX - OFF]);
  assign side_r = int'(taps[CTR_IDX + OFF]);

  if (WIDE) begin : g_wide
    assign ctr = CW'(2 * mid - side_l - side_r);
  end else begin : g_narrow
    assign ctr = CW'(2 * mid - side_l - side_r);
  end

endmodule

// File: rtl/lss_peaker.sv
module lss_peaker
  import lss_pkg::*;
#(
  parameter int DW  = 8,
  parameter int GW  = 6,
  localparam int CW = DW + 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [DW-1:0]         centre,
  input  logic signed [CW-1:0]  ctr,
  input  logic [DW-1:0]         env,
  input  logic [GW-1:0]         gain,
  input  logic [GW-1:0]         core,
  output logic [DW-1:0]         peak
);

  localparam int PMAX = (1 << DW) - 1;

  int ctr_v, cored_v, eff_v, corr_v, sum_v;
  logic in_core_band;

  always_comb begin
    ctr_v   = int'(ctr);
    cored_v = core_i(ctr_v, int'(core));
    eff_v   = eff_gain_i(int'(gain), GW, int'(env), DW);
    corr_v  = corr_i(cored_v, eff_v, GW);
    sum_v   = int'(centre) + corr_v;
  end

  assign peak         = DW'(clamp_i(sum_v, 0, PMAX));
  assign in_core_band = (ctr_v <= int'(core)) && (ctr_v >= -int'(core));

  // R5: a contour inside the coring band leaves the centre untouched
  a_r5_core_passes_centre: assert property (@(posedge clk) disable iff (!rst_n)
    in_core_band |-> (peak == centre));
  // R6: zero gain leaves the centre untouched
  a_r6_zero_gain: assert property (@(posedge clk) disable iff (!rst_n)
    (gain == '0) |-> (peak == centre));

endmodule

// File: rtl/luma_step_sharpener.sv
module luma_step_sharpener
  import lss_pkg::*;
#(
  parameter int DW = 8,
  parameter int GW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [DW-1:0] in_luma,
  input  logic          cfg_wide,
  input  logic [GW-1:0] cfg_gain,
  input  logic [GW-1:0] cfg_core,
  output logic          out_valid,
  output logic [DW-1:0] out_step,
  output logic [DW-1:0] out_peak,
  output logic [DW-1:0] out_env
);

  localparam int CW = DW + 3;

  logic [NTAP-1:0][DW-1:0] taps;
  logic [DW-1:0]           env_min, env_max, env_val;
  logic signed [CW-1:0]    ctr_wide, ctr_narrow, ctr_peak;
  logic [DW-1:0]           step_val, peak_val;
  logic                    step_pick_max;
  ksel_e                   ksel;
  logic                    v1_q, v2_q;
  logic [1:0]              since_rst;

  lss_taps #(.DW(DW)) u_taps (
    .clk(clk), .rst_n(rst_n), .shift(in_valid), .din(in_luma), .taps(taps)
  );

  lss_envelope #(.DW(DW)) u_env (
    .clk(clk), .rst_n(rst_n), .taps(taps),
    .win_min(env_min), .win_max(env_max), .win_env(env_val)
  );

  lss_contour #(.DW(DW), .WIDE(1'b1)) u_ctr_wide (
    .taps(taps), .ctr(ctr_wide)
  );

  lss_contour #(.DW(DW), .WIDE(1'b0)) u_ctr_narrow (
    .taps(taps), .ctr(ctr_narrow)
  );

  assign ksel          = ksel_e'(cfg_wide);
  assign ctr_peak      = (ksel == KSEL_WIDE) ? ctr_wide : ctr_narrow;
  assign step_pick_max = (ctr_wide < 0);
  assign step_val      = step_pick_max ? env_max : env_min;

  lss_peaker #(.DW(DW), .GW(GW)) u_peak (
    .clk(clk), .rst_n(rst_n), .centre(taps[CTR_IDX]), .ctr(ctr_peak),
    .env(env_val), .gain(cfg_gain), .core(cfg_core), .peak(peak_val)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v1_q <= 1'b0;
      v2_q <= 1'b0;
    end else begin
      v1_q <= in_valid;
      v2_q <= v1_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_step <= '0;
      out_peak <= '0;
      out_env  <= '0;
    end else if (v1_q) begin
      out_step <= step_val;
      out_peak <= peak_val;
      out_env  <= env_val;
    end
  end

  assign out_valid = v2_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                  since_rst <= '0;
    else if (since_rst != 2'd3)  since_rst <= since_rst + 2'd1;
  end

  // R8: fixed two-clock strobe latency
  a_r8_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd3) |-> (out_valid == $past(in_valid, 2)));
  // R8: outputs hold while no result is due
  a_r8_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !v1_q |=> ($stable(out_step) && $stable(out_peak) && $stable(out_env)));
  // R3: the step result is always one of the two envelope extremes
  a_r3_step_extreme: assert property (@(posedge clk) disable iff (!rst_n)
    v1_q |=> ((out_step == $past(env_max)) || (out_step == $past(env_min))));
  // R2: the reported envelope spans the step result
  a_r2_env_spans_step: assert property (@(posedge clk) disable iff (!rst_n)
    v1_q |=> (out_env == ($past(env_max) - $past(env_min))));

endmodule

// File: tb/tb_luma_step_sharpener.sv
module tb_luma_step_sharpener;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 11;

  typedef struct packed {
    logic [7:0] a, b, c, d, e;
    logic       wide;
    logic [5:0] gain, core;
    logic [7:0] x_step, x_peak, x_env;
  } vec_t;

  // window oldest..newest, kernel, gain, core, expected step/peak/env
  localparam vec_t VECS [NVEC] = '{
    '{8'd10,  8'd10,  8'd10,  8'd10,  8'd10,  1'b1, 6'd63, 6'd0, 8'd10,  8'd10,  8'd0},
    '{8'd0,   8'd0,   8'd0,   8'd100, 8'd100, 1'b0, 6'd63, 6'd0, 8'd100, 8'd0,   8'd100},
    '{8'd50,  8'd50,  8'd100, 8'd150, 8'd150, 1'b0, 6'd40, 6'd0, 8'd50,  8'd100, 8'd100},
    '{8'd100, 8'd100, 8'd120, 8'd100, 8'd100, 1'b1, 6'd32, 6'd5, 8'd100, 8'd138, 8'd20},
    '{8'd250, 8'd250, 8'd255, 8'd250, 8'd250, 1'b1, 6'd63, 6'd0, 8'd250, 8'd255, 8'd5},
    '{8'd100, 8'd100, 8'd104, 8'd100, 8'd100, 1'b1, 6'd63, 6'd8, 8'd100, 8'd104, 8'd4},
    '{8'd100, 8'd100, 8'd104, 8'd100, 8'd100, 1'b1, 6'd63, 6'd7, 8'd100, 8'd111, 8'd4},
    '{8'd0,   8'd100, 8'd50,  8'd100, 8'd0,   1'b0, 6'd16, 6'd0, 8'd0,   8'd35,  8'd100},
    '{8'd0,   8'd100, 8'd50,  8'd100, 8'd0,   1'b1, 6'd16, 6'd0, 8'd0,   8'd64,  8'd100},
    '{8'd0,   8'd0,   8'd200, 8'd0,   8'd0,   1'b1, 6'd0,  6'd0, 8'd0,   8'd200, 8'd200},
    '{8'd200, 8'd200, 8'd50,  8'd50,  8'd50,  1'b1, 6'd20, 6'd0, 8'd200, 8'd31,  8'd150}
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid;
  logic [7:0] in_luma;
  logic       cfg_wide;
  logic [5:0] cfg_gain, cfg_core;
  logic       out_valid;
  logic [7:0] out_step, out_peak, out_env;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  luma_step_sharpener dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_luma(in_luma),
    .cfg_wide(cfg_wide), .cfg_gain(cfg_gain), .cfg_core(cfg_core),
    .out_valid(out_valid), .out_step(out_step), .out_peak(out_peak),
    .out_env(out_env)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] x);
    @(negedge clk);
    in_valid = 1'b1;
    in_luma  = x;
  endtask

  // after the last push: drop valid, wait for the capture edge, sample
  task automatic settle();
    @(negedge clk);
    in_valid = 1'b0;
    in_luma  = 8'hA5;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] held;
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_luma  = 8'h00;
    cfg_wide = 1'b0;
    cfg_gain = 6'd0;
    cfg_core = 6'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9: reset state
    chk("R9 out_valid", int'(out_valid), 0);
    chk("R9 out_step",  int'(out_step), 0);
    chk("R9 out_peak",  int'(out_peak), 0);
    chk("R9 out_env",   int'(out_env), 0);

    // table walk: R2 R3 R4 R5 R6 R7
    for (int i = 0; i < NVEC; i++) begin
      cfg_wide = VECS[i].wide;
      cfg_gain = VECS[i].gain;
      cfg_core = VECS[i].core;
      push(VECS[i].a);
      push(VECS[i].b);
      push(VECS[i].c);
      push(VECS[i].d);
      push(VECS[i].e);
      settle();
      chk($sformatf("R8 valid vec%0d", i), int'(out_valid), 1);
      chk($sformatf("R3 step vec%0d", i),  int'(out_step), int'(VECS[i].x_step));
      chk($sformatf("R2 env vec%0d", i),   int'(out_env),  int'(VECS[i].x_env));
      chk($sformatf("R4/R5/R6/R7 peak vec%0d", i), int'(out_peak), int'(VECS[i].x_peak));
    end

    // R8: single strobe, two-clock latency, then hold
    cfg_wide = 1'b1; cfg_gain = 6'd0; cfg_core = 6'd0;
    @(negedge clk);
    push(8'd77);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R8 not yet valid", int'(out_valid), 0);
    @(negedge clk);
    chk("R8 valid after two", int'(out_valid), 1);
    held = out_step;
    @(negedge clk);
    chk("R8 valid one cycle", int'(out_valid), 0);
    in_luma = 8'd3;
    repeat (3) @(negedge clk);
    chk("R8 step holds", int'(out_step), int'(held));

    // R1: idle cycles with garbage do not enter the window
    push(8'd0);
    push(8'd0);
    @(negedge clk);
    in_valid = 1'b0;
    in_luma  = 8'd255;
    repeat (3) @(negedge clk);
    push(8'd200);
    push(8'd0);
    push(8'd0);
    settle();
    chk("R1 env with idle gap",  int'(out_env), 200);
    chk("R1 peak with idle gap", int'(out_peak), 200);
    chk("R1 step with idle gap", int'(out_step), 0);

    // R9: reset again mid-stream clears outputs
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    chk("R9 step after reset", int'(out_step), 0);
    chk("R9 env after reset",  int'(out_env), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule